// File: doc/BRIEF.md
# Recursive Half-Adder Adder

This block adds two unsigned W-bit operands (32 by default) by repeating half-additions until no carry is left. A start request loads the operands through one two-input selector per bit. The first step is a half-addition of the two operands. Each later step updates every bit position in parallel. A position combines its own previous sum bit with the carry just produced by the position below it.

A zero-carry detector ends the operation as soon as every internal carry is clear. It then raises a single-cycle done flag. Each step takes one clock cycle, so latency depends on the data. An addition with no carries at all finishes after the loading step. A carry that must run across the whole word takes W+1 steps. Carry chains that do not touch each other advance in the same cycles, so typical operands finish well before W+1.

The carry leaving the top bit is kept as a sticky carry-out flag and is never fed back. The block also reports how many half-addition steps the addition took.

Top module: `rih_adder`

## Requirements
- R1: When done is high, {cout, sum} equals the (W+1)-bit value a + b of the operands captured at the accepted start.
- R2: While reset is asserted and right after it, done, sum, cout and steps are all 0.
- R3: done is high for exactly one cycle per accepted start. steps then equals the number of half-addition steps taken (1 for the load plus 1 per carry iteration), and it never exceeds W+1.
- R4: Operands that produce no carry (a AND b equal to 0) raise done in the first cycle after the start edge, with steps = 1.
- R5: A carry chain across the full width (all ones plus 1) takes the maximum W+1 steps and gives sum = 0 and cout = 1.
- R6: Independent carry chains advance together. For W = 32, 0x3F050FC0 + 0x01300041 finishes with steps = 7.
- R7: start is ignored while an addition is in progress, including the cycle in which done is high. A request in that window changes neither the result nor the timing of the addition in progress.
- R8: After done, sum, cout and steps hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Addition request, taken only when idle |
| a | input | W | First operand, sampled with start |
| b | input | W | Second operand, sampled with start |
| sum | output | W | Sum bits, valid when done is high and held afterwards |
| cout | output | 1 | Carry out of the top bit, sticky during the addition |
| done | output | 1 | One-cycle completion pulse |
| steps | output | clog2(W+2) | Number of half-addition steps the last addition used |

## Verification
The assertions assume the operands are sampled only in the cycle in which start is accepted. They assume that a carry leaves the top bit at most once per addition, which holds because the operands are unsigned and the true sum fits in W+1 bits. The stimulus changes a and b only together with start and drives them at the falling edge. It also sends start requests during a running addition, and in its done cycle, with different operands, so the ignore rule is exercised without breaking the sampling assumption. The random pairs are unconstrained 32-bit values. The corner operands cover the no-carry, full-chain and split-chain cases.

// File: rtl/rih_adder.sv
module rih_adder #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  sum,
  output logic          cout,
  output logic          done,
  output logic [CW-1:0] steps
);

  logic          sel_q;
  logic [W-1:0]  s_q, c_q;
  logic          co_q;
  logic [CW-1:0] n_q;

  logic [W-1:0] cin, opx, opy, hs, hc;

  assign cin = {c_q[W-2:0], 1'b0};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign opx[i] = sel_q ? s_q[i] : a[i];
    assign opy[i] = sel_q ? cin[i] : b[i];
    assign hs[i]  = opx[i] ^ opy[i];
    assign hc[i]  = opx[i] & opy[i];
  end

  assign done  = sel_q & ~|c_q;
  assign sum   = s_q;
  assign cout  = co_q;
  assign steps = n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      s_q   <= '0;
      c_q   <= '0;
      co_q  <= 1'b0;
      n_q   <= '0;
    end else if (!sel_q) begin
      if (start) begin
        s_q   <= hs;
        c_q   <= hc;
        co_q  <= 1'b0;
        n_q   <= CW'(1);
        sel_q <= 1'b1;
      end
    end else if (done) begin
      sel_q <= 1'b0;
    end else begin
      s_q  <= hs;
      c_q  <= hc;
      co_q <= co_q | c_q[W-1];
      n_q  <= n_q + CW'(1);
    end
  end

  // R1
  ha_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |-> (c_q & s_q) == '0);

  // R1
  cout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !done && cout) |=> cout);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    steps <= CW'(W + 1));

  // R7
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !done) |=> (sel_q && steps == $past(steps) + CW'(1)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && !start) |=> ($stable(sum) && $stable(cout) && $stable(steps)));

endmodule

// File: tb/rih_adder_tb.sv
`timescale 1ns/1ps
module rih_adder_tb;
  localparam int W  = 32;
  localparam int CW = $clog2(W + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] sum;
  logic cout, done;
  logic [CW-1:0] steps;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rih_adder #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .sum(sum), .cout(cout), .done(done), .steps(steps)
  );

  function automatic int ref_steps(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s, c, t;
    int n;
    s = {1'b0, x} ^ {1'b0, y};
    c = {1'b0, x} & {1'b0, y};
    n = 1;
    while (c != '0) begin
      t = c << 1;
      c = s & t;
      s = s ^ t;
      n++;
    end
    return n;
  endfunction

  // behavioural reference
  logic         m_busy = 1'b0, m_valid = 1'b0;
  int           m_left = 0, m_n = 0;
  logic [W:0]   m_res = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_valid <= 1'b0; m_left <= 0; m_n <= 0; m_res <= '0;
    end else if (!m_busy) begin
      if (start) begin
        m_busy  <= 1'b1;
        m_n     <= ref_steps(a, b);
        m_left  <= ref_steps(a, b) - 1;
        m_res   <= {1'b0, a} + {1'b0, b};
        m_valid <= 1'b1;
      end
    end else if (m_left == 0) begin
      m_busy <= 1'b0;
    end else begin
      m_left <= m_left - 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(done == (m_busy && m_left == 0), "R3 done timing", done, m_busy && m_left == 0);
      if (m_busy && m_left == 0) begin
        check({cout, sum} == m_res, "R1 result", {cout, sum}, m_res);
        check(steps == m_n, "R3 step count", steps, m_n);
        check(steps <= W + 1, "R3 step bound", steps, W + 1);
      end
      if (!m_busy && m_valid) begin
        check({cout, sum} == m_res, "R8 held result", {cout, sum}, m_res);
        check(steps == m_n, "R8 held steps", steps, m_n);
      end
    end
  end

  task automatic add(input logic [W-1:0] x, input logic [W-1:0] y, output int n);
    @(negedge clk);
    start = 1'b1; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    n = steps;
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL R3 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && sum == '0 && cout == 1'b0 && steps == '0, "R2 reset state",
          {done, cout, sum}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && sum == '0 && steps == '0, "R2 after reset", {done, sum}, 0);

    // R4 no carries
    add(32'hA5A5_0F0F, 32'h5A5A_F0F0, n);
    check(n == 1, "R4 no-carry steps", n, 1);
    check(sum == 32'hFFFF_FFFF && cout == 1'b0, "R4 no-carry sum", sum, 32'hFFFF_FFFF);

    // R5 full chain
    add(32'hFFFF_FFFF, 32'h0000_0001, n);
    check(n == W + 1, "R5 full-chain steps", n, W + 1);
    check(sum == '0 && cout == 1'b1, "R5 full-chain result", {cout, sum}, 33'h1_0000_0000);

    // R6 independent chains
    add(32'h3F05_0FC0, 32'h0130_0041, n);
    check(n == 7, "R6 split-chain steps", n, 7);
    check(sum == 32'h4035_1001, "R6 split-chain sum", sum, 32'h4035_1001);

    // R8 hold across idle cycles
    repeat (5) @(negedge clk);
    check(sum == 32'h4035_1001 && steps == 7, "R8 idle hold", sum, 32'h4035_1001);

    // R7 start during busy and in the done cycle
    @(negedge clk);
    start = 1'b1; a = 32'hFFFF_FFFF; b = 32'h1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; a = 32'h1234_5678; b = 32'h1111_1111;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1; a = 32'h0000_0003; b = 32'h0000_0005;
    check(steps == W + 1 && sum == '0 && cout == 1'b1, "R7 busy request ignored", steps, W + 1);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && sum == '0 && steps == W + 1, "R7 done-cycle request ignored", sum, 0);

    // R1 random pairs
    for (int k = 0; k < 1000; k++) add($urandom, $urandom, n);
    add(32'h8000_0000, 32'h8000_0000, n);
    check(sum == '0 && cout == 1'b1 && n == 2, "R1 top-bit carry", {cout, sum}, 33'h1_0000_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule